// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Controller

This block sits in each node's cache controller and provides the processor's load-linked (LL) and store-conditional (SC) pair on top of a write-invalidate directory protocol. It keeps a single reservation: one valid flag and one line-address register. LL pairs never nest, so one register is enough.

An LL arms the reservation for the addressed line. If the line is not present in the local cache, the block first fetches a shared copy from the home node. The reservation is dropped when any of these happens:
- an invalidation snoop hits the reserved line,
- the processor switches context,
- any SC completes.

An SC fails at once if there is no reservation for its line. It succeeds at once if the line is already held exclusive. In every other case the block forwards the SC to the home node. It then applies the verdict that the home derives from its directory state. The home sends the invalidations to other sharers; the block only reports the result.

The processor interface takes one request at a time, accepted while `busy` is low. Every request ends with a one-cycle `done` pulse carrying `done_ok`. Requests to the home leave as one-cycle pulses. Exactly one response comes back for each of them.

Top module: `llsc_resv_ctl`

## Requirements
- R1: An LL sets the reservation to the line of its address; lines are compared with the offset bits (log2 of LINE_BYTES, default 32 bytes) ignored. With the line present (line_state 2'b01 shared or 2'b10 exclusive), `done` with `done_ok`=1 appears in the cycle after acceptance and no home request is made.
- R2: An LL with line_state 2'b00 (invalid) raises `home_req_valid` with `home_req_sc`=0 and the line-aligned address in the cycle after acceptance; `busy` stays high until the response, and `done` with `done_ok`=1 follows one cycle after `home_rsp_valid`.
- R3: An invalidation whose address falls in the reserved line clears the reservation; an invalidation of any other line leaves it intact.
- R4: An SC with no valid reservation fails locally: `done`=1, `done_ok`=0 in the cycle after acceptance, with no home request.
- R5: An SC with a valid reservation on its line and line_state 2'b10 succeeds locally in the cycle after acceptance, with no home request.
- R6: An SC with a valid reservation on its line and line_state other than 2'b10 raises `home_req_valid` with `home_req_sc`=1 in the next cycle. One cycle after `home_rsp_valid`, `done` is reported with `done_ok`=1 only if `home_rsp_dir` is 2'b01 (shared). The values 2'b00 (uncached) and 2'b10 (exclusive) both give failure.
- R7: A context-switch pulse clears the reservation.
- R8: Every SC, successful or not, leaves the reservation cleared.
- R9: An SC whose line differs from the reserved line fails locally, as in R4.
- R10: A home SC response arriving after an invalidation of the reserved line during the wait still reports the home verdict, and the reservation is cleared afterwards.
- R11: An LL accepted in the same cycle as a matching invalidation or a context switch keeps its new reservation.
- R12: After reset, `done`, `home_req_valid` and `busy` are 0 and no reservation is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request, taken when busy is low |
| req_sc | input | 1 | 1 = store-conditional, 0 = load-linked |
| req_addr | input | AW | Byte address of the request |
| line_state | input | 2 | Local state of the requested line: 00 invalid, 01 shared, 10 exclusive |
| inv_valid | input | 1 | Invalidation snoop arriving this cycle |
| inv_addr | input | AW | Address of the invalidated line |
| ctx_switch | input | 1 | Context-switch pulse |
| home_rsp_valid | input | 1 | Response from the home node |
| home_rsp_dir | input | 2 | Directory state seen by home: 00 uncached, 01 shared, 10 exclusive |
| busy | output | 1 | Waiting for a home response |
| done | output | 1 | Request complete (one cycle) |
| done_ok | output | 1 | Result qualifier for done |
| home_req_valid | output | 1 | Request to the home node (one cycle) |
| home_req_sc | output | 1 | 1 = SC arbitration, 0 = shared fill |
| home_req_addr | output | AW | Line-aligned address for the home request |

## Verification
Assertions check on every cycle:
- that an LL arms the reservation for its line,
- that a matching invalidation or a context switch disarms it,
- that an SC always disarms it,
- that local SC failures and exclusive-line successes complete in one cycle without touching the home,
- that a home SC verdict is reported exactly as shared-means-success.

The bench scenarios show the effects that only appear across several requests, observed through later SC outcomes at the ports:
- an invalidation of a different line having no effect,
- line-offset insensitivity,
- LL winning over a same-cycle invalidation,
- a verdict delivered after a mid-wait invalidation.

// File: rtl/llsc_resv_ctl.sv
`timescale 1ns/1ps
module llsc_resv_ctl #(
  parameter int AW = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_sc,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    line_state,
  input  logic          inv_valid,
  input  logic [AW-1:0] inv_addr,
  input  logic          ctx_switch,
  input  logic          home_rsp_valid,
  input  logic [1:0]    home_rsp_dir,
  output logic          busy,
  output logic          done,
  output logic          done_ok,
  output logic          home_req_valid,
  output logic          home_req_sc,
  output logic [AW-1:0] home_req_addr
);
  localparam int OFS = $clog2(LINE_BYTES);
  localparam int LW  = AW - OFS;
  localparam logic [1:0] LS_INV = 2'b00;
  localparam logic [1:0] LS_EXC = 2'b10;
  localparam logic [1:0] DIR_SHR = 2'b01;

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_SC} st_t;
  st_t st;

  logic          resv_v;
  logic [LW-1:0] resv_line;

  wire [LW-1:0] req_line = req_addr[AW-1:OFS];
  wire accept  = req_valid && (st == S_IDLE);
  wire ll_acc  = accept && !req_sc;
  wire sc_acc  = accept && req_sc;
  wire hit     = resv_v && (resv_line == req_line);
  wire inv_hit = inv_valid && (inv_addr[AW-1:OFS] == resv_line);

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st             <= S_IDLE;
      resv_v         <= 1'b0;
      resv_line      <= '0;
      done           <= 1'b0;
      done_ok        <= 1'b0;
      home_req_valid <= 1'b0;
      home_req_sc    <= 1'b0;
      home_req_addr  <= '0;
    end else begin
      done           <= 1'b0;
      home_req_valid <= 1'b0;
      if (inv_hit || ctx_switch) resv_v <= 1'b0;
      case (st)
        S_IDLE: begin
          if (ll_acc) begin
            resv_v    <= 1'b1;
            resv_line <= req_line;
            if (line_state == LS_INV) begin
              home_req_valid <= 1'b1;
              home_req_sc    <= 1'b0;
              home_req_addr  <= {req_line, {OFS{1'b0}}};
              st             <= S_FILL;
            end else begin
              done    <= 1'b1;
              done_ok <= 1'b1;
            end
          end else if (sc_acc) begin
            resv_v <= 1'b0;
            if (!hit) begin
              done    <= 1'b1;
              done_ok <= 1'b0;
            end else if (line_state == LS_EXC) begin
              done    <= 1'b1;
              done_ok <= 1'b1;
            end else begin
              home_req_valid <= 1'b1;
              home_req_sc    <= 1'b1;
              home_req_addr  <= {req_line, {OFS{1'b0}}};
              st             <= S_SC;
            end
          end
        end
        S_FILL: if (home_rsp_valid) begin
          done    <= 1'b1;
          done_ok <= 1'b1;
          st      <= S_IDLE;
        end
        S_SC: if (home_rsp_valid) begin
          done    <= 1'b1;
          done_ok <= (home_rsp_dir == DIR_SHR);
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_ll_arms_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ll_acc |=> resv_v && (resv_line == $past(req_line)));

  assert_inv_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_hit && !ll_acc) |=> !resv_v);

  assert_sc_nores_fails_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_acc && !resv_v) |=> done && !done_ok && !home_req_valid);

  assert_sc_excl_local_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_acc && hit && line_state == LS_EXC) |=> done && done_ok && !home_req_valid);

  assert_home_verdict_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SC && home_rsp_valid) |=> done && (done_ok == ($past(home_rsp_dir) == DIR_SHR)));

  assert_ctx_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_switch && !ll_acc) |=> !resv_v);

  assert_sc_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sc_acc |=> !resv_v);
endmodule

// File: tb/sim_llsc_resv_ctl.sv
`timescale 1ns/1ps
module sim_llsc_resv_ctl;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_sc = 0;
  logic [31:0] req_addr = 0, inv_addr = 0;
  logic [1:0] line_state = 0, home_rsp_dir = 0;
  logic inv_valid = 0, ctx_switch = 0, home_rsp_valid = 0;
  logic busy, done, done_ok, home_req_valid, home_req_sc;
  logic [31:0] home_req_addr;

  int checks = 0, fails = 0;
  bit q_ok[$];
  string q_tag[$];
  bit home_ok = 0;

  always #4 clk = ~clk;

  llsc_resv_ctl u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sc(req_sc),
    .req_addr(req_addr), .line_state(line_state), .inv_valid(inv_valid), .inv_addr(inv_addr),
    .ctx_switch(ctx_switch), .home_rsp_valid(home_rsp_valid), .home_rsp_dir(home_rsp_dir),
    .busy(busy), .done(done), .done_ok(done_ok), .home_req_valid(home_req_valid),
    .home_req_sc(home_req_sc), .home_req_addr(home_req_addr));

  task automatic chk(input bit c, input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!c) begin
      fails++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (home_req_valid && !home_ok) chk(0, "R4 R5 unexpected home request", 1, 0);
    if (done) begin
      if (q_ok.size() == 0) chk(0, "unexpected done", 1, 0);
      else begin
        bit e; string t;
        e = q_ok.pop_front(); t = q_tag.pop_front();
        chk(done_ok == e, t, done_ok, e);
      end
    end
  end

  // inv_at: 0 none, 1 same cycle as request, 2 while waiting on home
  task automatic op(input bit sc, input logic [31:0] a, input logic [1:0] ls,
                    input bit home, input logic [1:0] dir, input bit exp_ok,
                    input int inv_at, input string tag);
    q_ok.push_back(exp_ok); q_tag.push_back(tag);
    home_ok = home;
    @(negedge clk);
    req_valid = 1; req_sc = sc; req_addr = a; line_state = ls;
    if (inv_at == 1) begin inv_valid = 1; inv_addr = a; end
    @(negedge clk);
    req_valid = 0; inv_valid = 0;
    if (home) begin
      chk(home_req_valid && home_req_sc == sc && home_req_addr == (a & ~32'h1f) && busy,
          {tag, " home request"}, {home_req_valid, home_req_sc, home_req_addr[29:0]},
          {1'b1, sc, a[29:0] & ~30'h1f});
      if (inv_at == 2) begin inv_valid = 1; inv_addr = a; end
      home_rsp_valid = 1; home_rsp_dir = dir;
      @(negedge clk);
      home_rsp_valid = 0; inv_valid = 0;
    end
    @(negedge clk); @(negedge clk);
    home_ok = 0;
  endtask

  task automatic pulse_inv(input logic [31:0] a);
    @(negedge clk); inv_valid = 1; inv_addr = a;
    @(negedge clk); inv_valid = 0;
  endtask

  task automatic pulse_ctx();
    @(negedge clk); ctx_switch = 1;
    @(negedge clk); ctx_switch = 0;
  endtask

  localparam logic [31:0] A = 32'h0000_1040, B = 32'h0000_2080;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!done && !home_req_valid && !busy, "R12 reset outputs", {done, home_req_valid, busy}, 0);
    op(1, A, 2'b10, 0, 0, 0, 0, "R12 R4 SC after reset");

    op(0, A, 2'b01, 0, 0, 1, 0, "R1 LL hit");
    op(1, A + 8, 2'b10, 0, 0, 1, 0, "R5 R1 SC exclusive same line");
    op(1, A, 2'b10, 0, 0, 0, 0, "R8 SC after SC");

    op(0, A, 2'b00, 1, 0, 1, 0, "R2 LL miss fill");
    op(1, A, 2'b01, 1, 2'b01, 1, 0, "R6 home shared success");
    op(0, A, 2'b01, 0, 0, 1, 0, "R1 LL");
    op(1, A, 2'b01, 1, 2'b10, 0, 0, "R6 home exclusive fail");
    op(0, A, 2'b01, 0, 0, 1, 0, "R1 LL");
    op(1, A, 2'b00, 1, 2'b00, 0, 0, "R6 home uncached fail");
    op(1, A, 2'b10, 0, 0, 0, 0, "R8 SC after failed SC");

    op(0, A, 2'b01, 0, 0, 1, 0, "R1 LL");
    pulse_inv(A + 4);
    op(1, A, 2'b10, 0, 0, 0, 0, "R3 SC after matching invalidation");
    op(0, A, 2'b01, 0, 0, 1, 0, "R1 LL");
    pulse_inv(B);
    op(1, A, 2'b10, 0, 0, 1, 0, "R3 other-line invalidation ignored");

    op(0, A, 2'b01, 0, 0, 1, 0, "R1 LL");
    pulse_ctx();
    op(1, A, 2'b10, 0, 0, 0, 0, "R7 SC after context switch");

    op(0, A, 2'b01, 0, 0, 1, 0, "R1 LL");
    op(1, B, 2'b10, 0, 0, 0, 0, "R9 SC other line");

    op(0, A, 2'b01, 0, 0, 1, 0, "R1 LL");
    op(1, A, 2'b01, 1, 2'b01, 1, 2, "R10 verdict after mid-wait invalidation");
    op(1, A, 2'b10, 0, 0, 0, 0, "R10 reservation cleared");

    op(0, A, 2'b01, 0, 0, 1, 1, "R11 LL with same-cycle invalidation");
    op(1, A, 2'b10, 0, 0, 1, 0, "R11 reservation kept");
    q_ok.push_back(1); q_tag.push_back("R11 LL with same-cycle context switch");
    @(negedge clk); req_valid = 1; req_sc = 0; req_addr = B; line_state = 2'b10; ctx_switch = 1;
    @(negedge clk); req_valid = 0; ctx_switch = 0;
    @(negedge clk); @(negedge clk);
    op(1, B, 2'b10, 0, 0, 1, 0, "R11 reservation kept after context switch");

    repeat (3) @(negedge clk);
    chk(q_ok.size() == 0, "missing done", q_ok.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule